// File: doc/BRIEF.md
# Width-Matching FIFO with Narrow-Port Packing

This block is a first-in first-out store of 36-bit long words whose write port or read port can be narrowed to 18-bit words or 9-bit bytes. The other port always stays 36 bits wide. Three mode pins are captured while reset is held. A narrow write side gathers several pieces into one long word before the word enters storage. A narrow read side hands out a stored long word one piece at a time. In both directions the earliest piece occupies the least significant bits of the long word.

Each status flag is counted in the units of its own port. `full` counts write-port transfers, so a long word only frees its slot once every read piece of it has been taken. `valid` counts read-port transfers, so a long word that is still being packed stays invisible until its last piece arrives. Reads are show-ahead: while `valid` is high, `rd_data` already holds the next piece, and `rd_en` consumes it.

Top module: `busm_fifo`

## Requirements
- R1: The mode is taken from `cfg_bm`, `cfg_iw` and `cfg_ow` on clock edges while `rst_n` is low. After reset is released, changes on those pins have no effect on data or flags.
- R2: With `cfg_bm`=0, both ports are 36 bits wide, whatever the levels on `cfg_iw` and `cfg_ow`.
- R3: With `cfg_bm`=1, `{cfg_iw,cfg_ow}` selects the widths: 00 gives write 36 and read 18, 01 gives write 36 and read 9, 10 gives write 18 and read 36, 11 gives write 9 and read 36.
- R4: A narrow write uses only the low 18 or 9 bits of `wr_data`. The k-th piece of a long word (k starting at 0) fills bits [k*w +: w] of that word, where w is the write width.
- R5: A narrow read presents piece k of the head long word on the low w bits of `rd_data`, where w is the read width. Pieces are presented in rising k order and the upper bits are zero.
- R6: `full` is high exactly when the write-unit occupancy equals DEPTH times the write ratio. Write-unit occupancy is the stored long words times the write ratio, plus the pieces held in the packer. A stored word is released only after its last read piece, so with write 36 and read 9, `full` stays high until the fourth read.
- R7: `valid` is high exactly when at least one complete long word is stored. A partly packed word is not visible, so with write 18 and read 36, `valid` rises only after the second write.
- R8: A write while `full` is high, or a read while `valid` is low, changes neither the stored data nor the flags.
- R9: Reset clears the stored words and any partly packed or partly unpacked word. After reset, `full` and `valid` are low.
- R10: Data leaves in the order it was written, across any number of wrap-arounds of the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously; mode pins are captured while low |
| cfg_bm | input | 1 | Width-matching enable mode pin |
| cfg_iw | input | 1 | Write-width select mode pin |
| cfg_ow | input | 1 | Read-width select mode pin |
| wr_en | input | 1 | Write one write-port unit |
| wr_data | input | 36 | Write data, low bits used in narrow modes |
| full | output | 1 | No room for another write-port unit |
| rd_en | input | 1 | Consume the presented read-port unit |
| rd_data | output | 36 | Presented read-port unit, zero-extended |
| valid | output | 1 | A read-port unit is available |

## Verification
Every one of the five width modes is run through the same patterns: a fill to capacity plus one refused write, a drain to empty plus one refused read, and an interleaved run that wraps the storage. Filling and draining separate flags counted in write units from flags counted in read units. For example, `full` must hold across three byte reads and drop on the fourth. The refused transfers show that overflow and underflow leave the data untouched. The mode pins are inverted right after each reset, which tells a captured configuration from a live one. A final pattern leaves a half-packed or half-unpacked word in place, resets, and checks that the next word starts again at its least significant piece.

// File: rtl/busm_pkg.sv
package busm_pkg;

  typedef enum logic [2:0] {
    MODE_W36_R36,
    MODE_W36_R18,
    MODE_W36_R9,
    MODE_W18_R36,
    MODE_W9_R36
  } busm_mode_e;

  function automatic busm_mode_e mode_from_pins(input logic bm, input logic iw, input logic ow);
    busm_mode_e m;
    if (!bm) begin
      m = MODE_W36_R36;
    end else begin
      case ({iw, ow})
        2'b00:   m = MODE_W36_R18;
        2'b01:   m = MODE_W36_R9;
        2'b10:   m = MODE_W18_R36;
        default: m = MODE_W9_R36;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/busm_cfg.sv
module busm_cfg
  import busm_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_bm,
  input  logic                     cfg_iw,
  input  logic                     cfg_ow,
  output logic [$clog2(LANES)-1:0] wr_shift,
  output logic [$clog2(LANES)-1:0] rd_shift
);
  localparam int CNT_W = $clog2(LANES);
  localparam logic [CNT_W-1:0] SH_UNIT = CNT_W'(CNT_W);
  localparam logic [CNT_W-1:0] SH_HALF = CNT_W'(CNT_W - 1);

  busm_mode_e mode_d, mode_q;

  always_comb mode_d = mode_from_pins(cfg_bm, cfg_iw, cfg_ow);

  // mode register loads only while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= mode_d;
  end

  always_comb begin
    wr_shift = '0;
    rd_shift = '0;
    case (mode_q)
      MODE_W36_R18: rd_shift = SH_HALF;
      MODE_W36_R9:  rd_shift = SH_UNIT;
      MODE_W18_R36: wr_shift = SH_HALF;
      MODE_W9_R36:  wr_shift = SH_UNIT;
      default: ;
    endcase
  end

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q)); // R1

endmodule

// File: rtl/busm_pack.sv
module busm_pack #(
  parameter int UNIT_W = 9,
  parameter int LANES  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(LANES)-1:0]  sh,
  input  logic                      wr_en,
  input  logic                      full,
  input  logic [UNIT_W*LANES-1:0]   wr_data,
  output logic                      push,
  output logic [UNIT_W*LANES-1:0]   push_word,
  output logic [$clog2(LANES)-1:0]  wcnt
);
  localparam int WORD_W = UNIT_W * LANES;
  localparam int CNT_W  = $clog2(LANES);

  logic [CNT_W-1:0]  cnt_q, cnt_d, last_idx;
  logic [WORD_W-1:0] acc_q, acc_d, placed, mask;
  logic              accept;
  int                piece_w;

  always_comb begin
    piece_w  = WORD_W >> sh;
    last_idx = CNT_W'((1 << sh) - 1);
    mask     = {WORD_W{1'b1}} >> (WORD_W - piece_w);
    placed   = (wr_data & mask) << (int'(cnt_q) * piece_w);
    accept   = wr_en && !full;
    push      = 1'b0;
    push_word = acc_q | placed;
    cnt_d     = cnt_q;
    acc_d     = acc_q;
    if (accept) begin
      if (cnt_q == last_idx) begin
        push  = 1'b1;
        cnt_d = '0;
        acc_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
        acc_d = acc_q | placed;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (accept) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

  assign wcnt = cnt_q;

  AST_PACK_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_idx); // R4

endmodule

// File: rtl/busm_unpack.sv
module busm_unpack #(
  parameter int UNIT_W = 9,
  parameter int LANES  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(LANES)-1:0] sh,
  input  logic                     rd_en,
  input  logic                     avail,
  input  logic [UNIT_W*LANES-1:0]  head,
  output logic [UNIT_W*LANES-1:0]  rd_data,
  output logic                     pop
);
  localparam int WORD_W = UNIT_W * LANES;
  localparam int CNT_W  = $clog2(LANES);

  logic [CNT_W-1:0]  cnt_q, cnt_d, last_idx;
  logic [WORD_W-1:0] mask;
  logic              take;
  int                piece_w;

  always_comb begin
    piece_w  = WORD_W >> sh;
    last_idx = CNT_W'((1 << sh) - 1);
    mask     = {WORD_W{1'b1}} >> (WORD_W - piece_w);
    rd_data  = (head >> (int'(cnt_q) * piece_w)) & mask;
    take     = rd_en && avail;
    pop      = take && (cnt_q == last_idx);
    cnt_d    = pop ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (take) cnt_q <= cnt_d;
  end

  AST_UNPACK_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_idx); // R5

endmodule

// File: rtl/busm_store.sv
module busm_store #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 36
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [WORD_W-1:0]          push_word,
  input  logic                       pop,
  output logic [WORD_W-1:0]          head,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    wp_d  = push ? ((wp_q == LAST) ? '0 : wp_q + 1'b1) : wp_q;
    rp_d  = pop  ? ((rp_q == LAST) ? '0 : rp_q + 1'b1) : rp_q;
    cnt_d = cnt_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= push_word;
  end

  assign head  = mem_q[rp_q];
  assign count = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |-> (cnt_q < CW'(DEPTH))); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R8

endmodule

// File: rtl/busm_fifo.sv
module busm_fifo #(
  parameter int DEPTH  = 8,
  parameter int UNIT_W = 9,
  parameter int LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_bm,
  input  logic                    cfg_iw,
  input  logic                    cfg_ow,
  input  logic                    wr_en,
  input  logic [UNIT_W*LANES-1:0] wr_data,
  output logic                    full,
  input  logic                    rd_en,
  output logic [UNIT_W*LANES-1:0] rd_data,
  output logic                    valid
);
  localparam int WORD_W = UNIT_W * LANES;
  localparam int CNT_W  = $clog2(LANES);
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int OCC_W  = CW + CNT_W + 1;

  logic [CNT_W-1:0]  wr_shift, rd_shift, wcnt;
  logic              push, pop;
  logic [WORD_W-1:0] push_word, head;
  logic [CW-1:0]     count;
  logic [OCC_W-1:0]  occ, cap;

  busm_cfg #(.LANES(LANES)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_bm(cfg_bm), .cfg_iw(cfg_iw), .cfg_ow(cfg_ow),
    .wr_shift(wr_shift), .rd_shift(rd_shift)
  );

  busm_pack #(.UNIT_W(UNIT_W), .LANES(LANES)) u_pack (
    .clk(clk), .rst_n(rst_n), .sh(wr_shift), .wr_en(wr_en), .full(full),
    .wr_data(wr_data), .push(push), .push_word(push_word), .wcnt(wcnt)
  );

  busm_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .push_word(push_word), .pop(pop),
    .head(head), .count(count)
  );

  busm_unpack #(.UNIT_W(UNIT_W), .LANES(LANES)) u_unpack (
    .clk(clk), .rst_n(rst_n), .sh(rd_shift), .rd_en(rd_en), .avail(valid),
    .head(head), .rd_data(rd_data), .pop(pop)
  );

  // occupancy in write-port units
  always_comb begin
    occ   = (OCC_W'(count) << wr_shift) + OCC_W'(wcnt);
    cap   = OCC_W'(DEPTH) << wr_shift;
    full  = (occ == cap);
    valid = (count != '0);
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full); // R6
  AST_VALID_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> valid); // R7

endmodule

// File: tb/tb_busm_fifo.sv
module tb_busm_fifo;
  localparam int DEPTH = 4;
  localparam int W     = 36;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfg_bm = 1'b0, cfg_iw = 1'b0, cfg_ow = 1'b0;
  logic         wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic         full, valid;

  always #10 clk = ~clk;

  busm_fifo #(.DEPTH(DEPTH), .UNIT_W(9), .LANES(4)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_bm(cfg_bm), .cfg_iw(cfg_iw), .cfg_ow(cfg_ow),
    .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rd_en(rd_en), .rd_data(rd_data), .valid(valid)
  );

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] exp_q[$];
  int words, wpart, rread, wr_r, rd_r, seq;
  logic [W-1:0] acc;
  string tag;

  function automatic logic [W-1:0] mask_of(input int pw);
    logic [63:0] m;
    m = (64'd1 << pw) - 64'd1;
    return m[W-1:0];
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R9: reset with given pins; R1: pins inverted after release
  task automatic do_reset(input bit bm, input bit iw, input bit ow);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    cfg_bm = bm; cfg_iw = iw; cfg_ow = ow;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cfg_bm = ~bm; cfg_iw = ~iw; cfg_ow = ~ow;
    exp_q.delete(); words = 0; wpart = 0; rread = 0; acc = '0;
    if (!bm) begin wr_r = 1; rd_r = 1; tag = "R2"; end  // R2
    else begin
      tag = "R3";                                       // R3
      case ({iw, ow})
        2'b00: begin wr_r = 1; rd_r = 2; end
        2'b01: begin wr_r = 1; rd_r = 4; end
        2'b10: begin wr_r = 2; rd_r = 1; end
        default: begin wr_r = 4; rd_r = 1; end
      endcase
    end
    check("R9 full after reset", W'(full), '0);
    check("R9 valid after reset", W'(valid), '0);
  endtask

  task automatic do_write();
    logic [W-1:0] d;
    logic exp_full;
    int pw, rpw;
    d = {seq[8:0] ^ 9'h155, seq[8:0] + 9'd77, ~seq[8:0], seq[8:0]};
    seq++;
    @(negedge clk);
    exp_full = ((words * wr_r + wpart) == DEPTH * wr_r);
    check("R6 full in write units", W'(full), W'(exp_full));
    check("R7 valid in read units", W'(valid), W'(exp_q.size() != 0));
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!exp_full) begin  // R8: a refused write leaves no trace
      pw  = W / wr_r;
      rpw = W / rd_r;
      acc = acc | ((d & mask_of(pw)) << (wpart * pw));
      wpart++;
      if (wpart == wr_r) begin
        words++;
        for (int i = 0; i < rd_r; i++) exp_q.push_back((acc >> (i * rpw)) & mask_of(rpw));
        acc = '0; wpart = 0;
      end
    end
  endtask

  task automatic do_read();
    bit ok;
    @(negedge clk);
    ok = (exp_q.size() != 0);
    check("R6 full in write units", W'(full), W'((words * wr_r + wpart) == DEPTH * wr_r));
    check("R7 R8 valid", W'(valid), W'(ok));
    if (ok) check({tag, " data R1 R4 R5 R10"}, rd_data, exp_q[0]);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (ok) begin
      void'(exp_q.pop_front());
      rread++;
      if (rread == rd_r) begin rread = 0; words--; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    bit [2:0] modes [5];
    modes = '{3'b011, 3'b100, 3'b101, 3'b110, 3'b111};
    seq = 1;
    foreach (modes[m]) begin
      do_reset(modes[m][2], modes[m][1], modes[m][0]);
      repeat (DEPTH * wr_r + 1) do_write();     // fill plus refused write (R6, R8)
      repeat (DEPTH * rd_r + 1) do_read();      // drain plus refused read (R8)
      repeat (2 * wr_r) do_write();             // interleaved wrap (R10)
      repeat (rd_r) do_read();
      repeat (3 * wr_r) do_write();
      repeat (4 * rd_r + 1) do_read();
      // R9: abandon a partial word on either side, then restart
      do_write();
      if (exp_q.size() != 0) do_read();
      do_reset(modes[m][2], modes[m][1], modes[m][0]);
      repeat (wr_r) do_write();
      repeat (rd_r + 1) do_read();
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule